// File: doc/BRIEF.md
# Manchester Transmit Framer with Command/Data Sync

This block turns one character at a time into a Manchester-coded serial frame on a single output line. Each frame opens with an optional run of encoded preamble bits in one of four patterns. A start delimiter follows, and then the character itself, least significant bit first. The delimiter is either one encoded zero bit or a three-bit-time sync waveform. The sync waveform breaks Manchester rules on purpose: its only transition falls in the middle of its second bit time. Its polarity tells the far end whether the character that follows is a command or plain data.

The line is advanced only on a tick supplied at twice the bit rate, so every half-bit lasts exactly one tick interval. This lets the 1.5-bit halves of the sync waveform be produced exactly. A character enters through a valid/ready handshake. The command/data choice comes from a global setting, or from a bit that travels with each character when per-character selection is enabled. All settings and the per-character bit are captured at the handshake, so a change made during a frame does not affect that frame.

Top module: `mtx_framer`

## Requirements
- R1: After reset and between frames, `tx_line` is high and `in_ready` is high. `in_ready` is low from the cycle after a handshake until the frame has finished.
- R2: `tx_line` changes only on the clock edge at which `half_tick` is sampled high. Each half-bit of a frame lasts from one tick to the next.
- R3: Every encoded bit takes two half-bits. A one is sent as high then low, and a zero as low then high.
- R4: `cfg_pat` selects the preamble bit sequence. Code 0 gives 0,1,0,1… starting with 0. Code 1 gives 1,0,1,0… starting with 1. Code 2 gives all zeros and code 3 gives all ones.
- R5: `cfg_pre_len` gives the number of preamble bits, from 0 to 15. The value 8 is the usual setting, and 0 leaves out the preamble.
- R6: With `cfg_one_bit`=1, the delimiter is one encoded zero (low half, then high half).
- R7: With `cfg_one_bit`=0, the delimiter lasts six half-bits. Command sync is three high halves followed by three low halves. Data sync is three low halves followed by three high halves.
- R8: With `cfg_per_char`=0, `cfg_glob_cmd`=1 selects command sync and 0 selects data sync, and `in_cmd` has no effect. With `cfg_per_char`=1, `in_cmd` selects the sync type in the same way, and `cfg_glob_cmd` has no effect.
- R9: Data bits follow the delimiter LSB first. Their count is 5 + `cfg_char_len`, so codes 0..3 give 5..8 bits.
- R10: The data, `in_cmd` and all configuration inputs are sampled at the handshake. Changing them afterwards does not alter the frame in progress.
- R11: One tick after the last data half-bit begins, `tx_line` returns high and `in_ready` goes high at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_tick | input | 1 | One-cycle pulse at twice the bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Framer idle and able to accept a character |
| in_data | input | CHAR_MAX | Character, LSB sent first |
| in_cmd | input | 1 | Per-character sync type (1 = command) |
| cfg_pat | input | 2 | Preamble pattern code |
| cfg_pre_len | input | PLEN_W | Preamble length in bit times |
| cfg_one_bit | input | 1 | 1 = single start bit, 0 = sync waveform |
| cfg_per_char | input | 1 | 1 = sync type taken from `in_cmd` |
| cfg_glob_cmd | input | 1 | Global sync type (1 = command) |
| cfg_char_len | input | CLEN_W | Character length code (bits = 5 + code) |
| tx_line | output | 1 | Serial output line |

## Verification
The bench drives preamble lengths of 0, 1, 8 and 15. A framer that mishandles length zero would send a stray preamble bit, or would stall before the delimiter. Both sync polarities are checked under global and per-character selection. Each case sets the ignored selector to the opposite value, so a design that reads the wrong source sends the inverted six-half-bit waveform. Configuration and data are scrambled right after the handshake, which catches any design that reads live inputs in the middle of a frame. Ticks arrive every cycle and also sparsely, so a framer that advances on the clock instead of the tick, or that frees `in_ready` a tick early or late, is out of step with the reference model.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_SFD  = 3'd2,
    ST_DATA = 3'd3,
    ST_TAIL = 3'd4
  } mtx_state_e;

  localparam logic [1:0] PAT_ZO   = 2'd0;
  localparam logic [1:0] PAT_OZ   = 2'd1;
  localparam logic [1:0] PAT_ZERO = 2'd2;
  localparam logic [1:0] PAT_ONE  = 2'd3;

  localparam int unsigned HCNT_W   = 3;
  localparam int unsigned SYNC_HALF = 3;
endpackage

// File: rtl/mtx_rst_sync.sv
module mtx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/mtx_capture.sv
module mtx_capture #(
  parameter int unsigned PLEN_W   = 4,
  parameter int unsigned CLEN_W   = 2,
  parameter int unsigned CHAR_MAX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CHAR_MAX-1:0] data_in,
  input  logic                cmd_in,
  input  logic [1:0]          pat_in,
  input  logic [PLEN_W-1:0]   plen_in,
  input  logic                one_in,
  input  logic [CLEN_W-1:0]   clen_in,
  output logic [CHAR_MAX-1:0] data_q,
  output logic                cmd_q,
  output logic [1:0]          pat_q,
  output logic [PLEN_W-1:0]   plen_q,
  output logic                one_q,
  output logic [CLEN_W-1:0]   clen_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= 1'b0;
      pat_q  <= '0;
      plen_q <= '0;
      one_q  <= 1'b0;
      clen_q <= '0;
    end else if (load) begin
      data_q <= data_in;
      cmd_q  <= cmd_in;
      pat_q  <= pat_in;
      plen_q <= plen_in;
      one_q  <= one_in;
      clen_q <= clen_in;
    end
  end
endmodule

// File: rtl/mtx_seq.sv
module mtx_seq
  import mtx_pkg::*;
#(
  parameter int unsigned PLEN_W   = 4,
  parameter int unsigned CLEN_W   = 2,
  parameter int unsigned MIN_CHAR = 5,
  parameter int unsigned BIT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              load,
  input  logic [PLEN_W-1:0] plen_now,
  input  logic [PLEN_W-1:0] plen_q,
  input  logic [CLEN_W-1:0] clen_q,
  input  logic              one_q,
  output mtx_state_e        state_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic [HCNT_W-1:0] hcnt_q
);
  mtx_state_e        state_n;
  logic [BIT_W-1:0]  bit_n;
  logic [HCNT_W-1:0] hcnt_n;
  logic [BIT_W-1:0]  pre_last;
  logic [BIT_W-1:0]  data_last;
  logic [HCNT_W-1:0] sfd_last;

  assign pre_last  = BIT_W'(plen_q) - BIT_W'(1);
  assign data_last = BIT_W'(MIN_CHAR - 1) + BIT_W'(clen_q);
  assign sfd_last  = one_q ? HCNT_W'(1) : HCNT_W'(2 * SYNC_HALF - 1);

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    hcnt_n  = hcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load) begin
          state_n = (plen_now == '0) ? ST_SFD : ST_PRE;
          bit_n   = '0;
          hcnt_n  = '0;
        end
      end
      ST_PRE: begin
        if (half_tick) begin
          if (hcnt_q == HCNT_W'(1)) begin
            hcnt_n = '0;
            if (bit_q == pre_last) begin
              state_n = ST_SFD;
              bit_n   = '0;
            end else begin
              bit_n = bit_q + BIT_W'(1);
            end
          end else begin
            hcnt_n = HCNT_W'(1);
          end
        end
      end
      ST_SFD: begin
        if (half_tick) begin
          if (hcnt_q == sfd_last) begin
            hcnt_n  = '0;
            bit_n   = '0;
            state_n = ST_DATA;
          end else begin
            hcnt_n = hcnt_q + HCNT_W'(1);
          end
        end
      end
      ST_DATA: begin
        if (half_tick) begin
          if (hcnt_q == HCNT_W'(1)) begin
            hcnt_n = '0;
            if (bit_q == data_last) state_n = ST_TAIL;
            else                    bit_n   = bit_q + BIT_W'(1);
          end else begin
            hcnt_n = HCNT_W'(1);
          end
        end
      end
      ST_TAIL: begin
        if (half_tick) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      hcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      hcnt_q  <= hcnt_n;
    end
  end
endmodule

// File: rtl/mtx_level.sv
module mtx_level
  import mtx_pkg::*;
#(
  parameter int unsigned CHAR_MAX = 8,
  parameter int unsigned BIT_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                half_tick,
  input  mtx_state_e          state_q,
  input  logic [BIT_W-1:0]    bit_q,
  input  logic [HCNT_W-1:0]   hcnt_q,
  input  logic [1:0]          pat_q,
  input  logic                one_q,
  input  logic                cmd_q,
  input  logic [CHAR_MAX-1:0] data_q,
  output logic                line_q
);
  logic                pre_bit;
  logic                data_bit;
  logic [CHAR_MAX-1:0] data_shift;
  logic                level;
  logic                line_n;

  assign data_shift = data_q >> bit_q;
  assign data_bit   = data_shift[0];

  always_comb begin
    unique case (pat_q)
      PAT_ZO:   pre_bit = bit_q[0];
      PAT_OZ:   pre_bit = ~bit_q[0];
      PAT_ZERO: pre_bit = 1'b0;
      default:  pre_bit = 1'b1;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:  level = (hcnt_q == '0) ? pre_bit : ~pre_bit;
      ST_SFD: begin
        if (one_q) level = (hcnt_q != '0);
        else       level = (hcnt_q < HCNT_W'(SYNC_HALF)) ? cmd_q : ~cmd_q;
      end
      ST_DATA: level = (hcnt_q == '0) ? data_bit : ~data_bit;
      default: level = 1'b1;
    endcase
  end

  always_comb begin
    line_n = line_q;
    if (half_tick && (state_q != ST_IDLE)) line_n = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_n;
  end
endmodule

// File: rtl/mtx_framer.sv
module mtx_framer
  import mtx_pkg::*;
#(
  parameter int unsigned PLEN_W   = 4,
  parameter int unsigned CLEN_W   = 2,
  parameter int unsigned CHAR_MAX = 8,
  parameter int unsigned MIN_CHAR = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                half_tick,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CHAR_MAX-1:0] in_data,
  input  logic                in_cmd,
  input  logic [1:0]          cfg_pat,
  input  logic [PLEN_W-1:0]   cfg_pre_len,
  input  logic                cfg_one_bit,
  input  logic                cfg_per_char,
  input  logic                cfg_glob_cmd,
  input  logic [CLEN_W-1:0]   cfg_char_len,
  output logic                tx_line
);
  localparam int unsigned IDX_W = (CHAR_MAX > 1) ? $clog2(CHAR_MAX) : 1;
  localparam int unsigned BIT_W = (PLEN_W > IDX_W) ? PLEN_W : IDX_W;

  logic                rst_q_n;
  logic                load;
  logic                sel_cmd;
  logic [CHAR_MAX-1:0] data_q;
  logic                cmd_q;
  logic [1:0]          pat_q;
  logic [PLEN_W-1:0]   plen_q;
  logic                one_q;
  logic [CLEN_W-1:0]   clen_q;
  mtx_state_e          state_q;
  logic [BIT_W-1:0]    bit_q;
  logic [HCNT_W-1:0]   hcnt_q;

  assign in_ready = (state_q == ST_IDLE);
  assign load     = in_valid && in_ready;
  assign sel_cmd  = cfg_per_char ? in_cmd : cfg_glob_cmd;

  mtx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  mtx_capture #(.PLEN_W(PLEN_W), .CLEN_W(CLEN_W), .CHAR_MAX(CHAR_MAX)) u_cap (
    .clk(clk), .rst_n(rst_q_n), .load(load),
    .data_in(in_data), .cmd_in(sel_cmd), .pat_in(cfg_pat),
    .plen_in(cfg_pre_len), .one_in(cfg_one_bit), .clen_in(cfg_char_len),
    .data_q(data_q), .cmd_q(cmd_q), .pat_q(pat_q),
    .plen_q(plen_q), .one_q(one_q), .clen_q(clen_q)
  );

  mtx_seq #(.PLEN_W(PLEN_W), .CLEN_W(CLEN_W), .MIN_CHAR(MIN_CHAR), .BIT_W(BIT_W)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .half_tick(half_tick), .load(load),
    .plen_now(cfg_pre_len), .plen_q(plen_q), .clen_q(clen_q), .one_q(one_q),
    .state_q(state_q), .bit_q(bit_q), .hcnt_q(hcnt_q)
  );

  mtx_level #(.CHAR_MAX(CHAR_MAX), .BIT_W(BIT_W)) u_lvl (
    .clk(clk), .rst_n(rst_q_n), .half_tick(half_tick),
    .state_q(state_q), .bit_q(bit_q), .hcnt_q(hcnt_q),
    .pat_q(pat_q), .one_q(one_q), .cmd_q(cmd_q), .data_q(data_q),
    .line_q(tx_line)
  );
endmodule

// File: rtl/mtx_chk.sv
module mtx_chk (
  input logic clk,
  input logic rst_n,
  input logic half_tick,
  input logic in_valid,
  input logic in_ready,
  input logic tx_line
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_line);

  // R1
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_line) |-> $past(half_tick));

  // R11
  ready_returns_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(half_tick));
endmodule

bind mtx_framer mtx_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .half_tick(half_tick),
  .in_valid(in_valid), .in_ready(in_ready), .tx_line(tx_line)
);

// File: tb/sim_mtx_framer.sv
`timescale 1ns/1ps
module sim_mtx_framer;
  logic       clk;
  logic       rst_n;
  logic       half_tick;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       in_cmd;
  logic [1:0] cfg_pat;
  logic [3:0] cfg_pre_len;
  logic       cfg_one_bit;
  logic       cfg_per_char;
  logic       cfg_glob_cmd;
  logic [1:0] cfg_char_len;
  logic       tx_line;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    tick_div = 3;
  int    div_cnt = 0;
  bit    checking = 0;
  string cur_tag = "R1";

  bit m_busy = 0;
  bit m_line = 1;
  bit mq[$];

  mtx_framer u0 (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_cmd(in_cmd),
    .cfg_pat(cfg_pat), .cfg_pre_len(cfg_pre_len), .cfg_one_bit(cfg_one_bit),
    .cfg_per_char(cfg_per_char), .cfg_glob_cmd(cfg_glob_cmd),
    .cfg_char_len(cfg_char_len), .tx_line(tx_line)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (div_cnt >= tick_div - 1) begin half_tick = 1; div_cnt = 0; end
    else begin half_tick = 0; div_cnt++; end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic enc(bit b);
    mq.push_back(b);
    mq.push_back(!b);
  endtask

  // Expected half-bit stream built from R3..R9
  task automatic build();
    bit cmd;
    cmd = cfg_per_char ? in_cmd : cfg_glob_cmd;
    for (int i = 0; i < int'(cfg_pre_len); i++) begin
      case (cfg_pat)
        2'd0: enc(bit'(i % 2));
        2'd1: enc(!bit'(i % 2));
        2'd2: enc(1'b0);
        default: enc(1'b1);
      endcase
    end
    if (cfg_one_bit) enc(1'b0);
    else for (int k = 0; k < 6; k++) mq.push_back((k < 3) ? cmd : !cmd);
    for (int i = 0; i < 5 + int'(cfg_char_len); i++) enc(in_data[i]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_line = 1; mq.delete();
    end else if (m_busy) begin
      if (half_tick) begin
        if (mq.size() > 0) m_line = mq.pop_front();
        else begin m_line = 1; m_busy = 0; end
      end
    end else if (in_valid) begin
      build();
      m_busy = 1;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      check(cur_tag, tx_line, m_line, "line");
      check(cur_tag, in_ready, !m_busy, "ready");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(string tag, logic [7:0] d, logic [1:0] pat, logic [3:0] plen,
                      bit onebit, bit perc, bit glob, bit ccmd, logic [1:0] clen, bit scramble);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    cur_tag = tag;
    in_data = d; cfg_pat = pat; cfg_pre_len = plen; cfg_one_bit = onebit;
    cfg_per_char = perc; cfg_glob_cmd = glob; in_cmd = ccmd; cfg_char_len = clen;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    if (scramble) begin
      in_data = ~in_data; cfg_pat = ~cfg_pat; cfg_pre_len = ~cfg_pre_len;
      cfg_one_bit = !cfg_one_bit; cfg_per_char = !cfg_per_char;
      cfg_glob_cmd = !cfg_glob_cmd; in_cmd = !in_cmd; cfg_char_len = ~cfg_char_len;
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    // R11: line back at idle level once ready returns
    check("R11", tx_line, 1'b1, "idle after frame");
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_data = 0; in_cmd = 0; cfg_pat = 0; cfg_pre_len = 0;
    cfg_one_bit = 1; cfg_per_char = 0; cfg_glob_cmd = 0; cfg_char_len = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", tx_line, 1'b1, "line in reset");
    check("R1", in_ready, 1'b1, "ready in reset");
    rst_n = 1;
    repeat (6) @(negedge clk);
    checking = 1;

    send("R3", 8'hA5, 2'd0, 4'd0, 1, 0, 0, 0, 2'd3, 0);
    send("R3", 8'h00, 2'd0, 4'd0, 1, 0, 0, 0, 2'd3, 0);
    send("R3", 8'hFF, 2'd0, 4'd0, 1, 0, 0, 0, 2'd3, 0);
    for (int p = 0; p < 4; p++) send("R4", 8'h3C, 2'(p), 4'd8, 1, 0, 0, 0, 2'd3, 0);
    send("R5", 8'h5A, 2'd1, 4'd15, 0, 0, 1, 0, 2'd3, 0);
    send("R5", 8'h5A, 2'd0, 4'd1, 0, 0, 0, 0, 2'd3, 0);
    send("R5", 8'h5A, 2'd3, 4'd0, 0, 0, 1, 0, 2'd3, 0);
    send("R6", 8'h81, 2'd3, 4'd4, 1, 0, 1, 1, 2'd3, 0);
    send("R7", 8'h96, 2'd0, 4'd8, 0, 0, 1, 0, 2'd3, 0);
    send("R7", 8'h96, 2'd0, 4'd8, 0, 0, 0, 1, 2'd3, 0);
    send("R8", 8'h47, 2'd2, 4'd2, 0, 1, 1, 0, 2'd3, 0);
    send("R8", 8'h47, 2'd2, 4'd2, 0, 1, 0, 1, 2'd3, 0);
    send("R8", 8'h47, 2'd2, 4'd2, 0, 0, 0, 1, 2'd3, 0);
    for (int c = 0; c < 4; c++) send("R9", 8'hE3, 2'd1, 4'd3, 0, 0, 1, 0, 2'(c), 0);
    send("R10", 8'h6B, 2'd0, 4'd5, 0, 0, 1, 0, 2'd1, 1);
    send("R10", 8'h94, 2'd2, 4'd0, 1, 1, 0, 1, 2'd2, 1);
    tick_div = 1;
    send("R2", 8'hC3, 2'd1, 4'd6, 0, 1, 0, 1, 2'd3, 0);
    send("R2", 8'h1E, 2'd3, 4'd0, 1, 0, 0, 0, 2'd0, 0);
    tick_div = 5;
    send("R2", 8'h72, 2'd0, 4'd2, 0, 0, 0, 0, 2'd2, 0);
    repeat (12) @(negedge clk);
    checking = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule